// File: doc/BRIEF.md
# Access Control Region Matcher

This block classifies every memory access against a small file of region descriptors. Each descriptor names an address window, the privilege modes it applies to, the cache policy for accesses that fall inside it, and two protection flags. For each access the block takes the address, a supervisor/user flag and a write flag. One cycle later it returns whether any descriptor matched, the cache policy to use and whether the access breaks a protection rule.

Descriptors are loaded and read back through a simple word-wide configuration port. Each descriptor is a 32-bit word. Bits 31:24 hold the region base byte and bits 23:16 hold a mask byte. Bits 14:13 hold the privilege-match field. Bit 10 selects the fine compare mode. Bits 6:5 hold the cache policy. Bit 3 is the supervisor-only flag and bit 2 is the write-protect flag. All other bits are reserved. When no descriptor matches, the cache policy comes from an input supplied by the surrounding logic.

The address compare has two forms. The coarse form compares the top address byte with the base byte, and a set bit in the mask byte removes the matching address bit from the compare. The fine form compares the top address byte exactly. It also compares address bits 23:20 against descriptor bits 23:20, and a set bit in descriptor bits 19:16 removes the matching address bit from that compare. The fine form can therefore describe regions from 1 MB to 16 MB.

Top module: `region_attr_matcher`

## Requirements
- R1: While rst_n is low, every descriptor reads back as zero and hit, cmode and acc_err are all zero.
- R2: A write with cfg_we high stores cfg_wdata into descriptor cfg_sel. The bits that can be stored are 31:16, 14:13, 10, 6:5 and 3, plus bit 2 in descriptors 0 and 1 only. Every other bit reads back as zero. cfg_rdata always shows descriptor cfg_sel.
- R3: When bit 10 is 0, the address matches if acc_addr[31:24] equals bits 31:24 in every position where mask bits 23:16 are clear.
- R4: When bit 10 is 1, acc_addr[31:24] must equal bits 31:24 exactly. acc_addr[23:20] must also equal bits 23:20 in every position where bits 19:16 are clear.
- R5: Privilege field bits 14:13 set which accesses can match. A value of 00 matches only user accesses (acc_super=0). A value of 01 matches only supervisor accesses. A value of 1x matches both.
- R6: On a hit, cmode takes the descriptor's bits 6:5. The encodings are 00 write-through, 01 copyback, 10 inhibited precise and 11 inhibited imprecise.
- R7: A hit on a descriptor with bit 3 set raises acc_err for a user access and not for a supervisor access.
- R8: A write access (acc_write=1) that hits descriptor 0 or 1 with bit 2 set raises acc_err. Descriptors 2 and 3 never raise a write-protect error, even if software writes 1 to their bit 2.
- R9: When several descriptors match, the lowest-numbered one supplies cmode and decides acc_err.
- R10: When no descriptor matches, hit is 0, acc_err is 0, and cmode equals the dflt_cmode sampled with the access.
- R11: Results appear on the clock edge after the access inputs are sampled. The compare uses the descriptor contents that were in place before any configuration write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 2 | Descriptor index for write and read |
| cfg_wdata | input | 32 | Descriptor write word |
| cfg_rdata | output | 32 | Selected descriptor, reserved bits zero |
| acc_addr | input | 32 | Access address |
| acc_super | input | 1 | 1 = supervisor access, 0 = user access |
| acc_write | input | 1 | 1 = write access |
| dflt_cmode | input | 2 | Cache policy used when nothing matches |
| hit | output | 1 | Some descriptor matched (registered) |
| cmode | output | 2 | Selected cache policy (registered) |
| acc_err | output | 1 | Protection violation (registered) |

## Verification
The hardest case is an access that several descriptors match at once, where those descriptors disagree on privilege, protection and cache policy. Only then can a wrong priority order or a protection flag taken from the wrong descriptor show at the ports. Reaching it needs overlapping windows, some coarse and some fine, with the masked bit positions placed so that an address hits one region and just misses another. The directed part builds these overlaps by hand. A long random phase then draws each address from a descriptor's own base, so that most accesses land in or next to configured windows. Same-cycle writes and accesses are mixed in to exercise the old-contents rule.

// File: rtl/region_attr_pkg.sv
package region_attr_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BASE_LO = 24;
  localparam int unsigned MASK_LO = 16;
  localparam int unsigned PRIV_LO = 13;
  localparam int unsigned FINE_BIT = 10;
  localparam int unsigned CM_LO   = 5;
  localparam int unsigned SP_BIT  = 3;
  localparam int unsigned WP_BIT  = 2;

  typedef struct packed {
    logic [7:0] base;
    logic [7:0] mask;
    logic [1:0] priv;
    logic       fine;
    logic [1:0] cmode;
    logic       sprot;
    logic       wprot;
  } region_cfg_t;

  function automatic logic [WORD_W-1:0] cfg_to_word(region_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BASE_LO +: 8] = c.base;
    w[MASK_LO +: 8] = c.mask;
    w[PRIV_LO +: 2] = c.priv;
    w[FINE_BIT]     = c.fine;
    w[CM_LO +: 2]   = c.cmode;
    w[SP_BIT]       = c.sprot;
    w[WP_BIT]       = c.wprot;
    return w;
  endfunction

  function automatic region_cfg_t word_to_cfg(logic [WORD_W-1:0] w);
    region_cfg_t c;
    c.base  = w[BASE_LO +: 8];
    c.mask  = w[MASK_LO +: 8];
    c.priv  = w[PRIV_LO +: 2];
    c.fine  = w[FINE_BIT];
    c.cmode = w[CM_LO +: 2];
    c.sprot = w[SP_BIT];
    c.wprot = w[WP_BIT];
    return c;
  endfunction

endpackage

// File: rtl/region_cfg_file.sv
module region_cfg_file
  import region_attr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 4,
  parameter int unsigned WP_REGIONS  = 2,
  localparam int unsigned SEL_W      = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output region_cfg_t       cfg_o [NUM_REGIONS]
);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
    localparam bit HAS_WP = (g < WP_REGIONS);
    region_cfg_t q;
    region_cfg_t d;
    logic        en;

    always_comb begin
      en      = we_i && (sel_i == SEL_W'(g));
      d       = word_to_cfg(wdata_i);
      d.wprot = HAS_WP ? d.wprot : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign cfg_o[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (sel_i == SEL_W'(i)) rdata_o = cfg_to_word(cfg_o[i]);
    end
  end

endmodule

// File: rtl/region_addr_cmp.sv
module region_addr_cmp
  import region_attr_pkg::*;
(
  input  region_cfg_t       cfg_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic              super_i,
  output logic              hit_o
);

  logic [7:0] care_top;
  logic [3:0] care_mid;
  logic       top_ok;
  logic       mid_ok;
  logic       priv_ok;

  always_comb begin
    if (cfg_i.fine) begin
      care_top = '1;
      care_mid = ~cfg_i.mask[3:0];
    end else begin
      care_top = ~cfg_i.mask;
      care_mid = '0;
    end
    top_ok  = ((addr_i[31:24] ^ cfg_i.base) & care_top) == 8'h00;
    mid_ok  = ((addr_i[23:20] ^ cfg_i.mask[7:4]) & care_mid) == 4'h0;
    priv_ok = cfg_i.priv[1] | (cfg_i.priv[0] == super_i);
    hit_o   = top_ok & mid_ok & priv_ok;
  end

endmodule

// File: rtl/region_prio_select.sv
module region_prio_select
  import region_attr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 4
) (
  input  logic [NUM_REGIONS-1:0] hit_vec_i,
  input  region_cfg_t            cfg_i [NUM_REGIONS],
  input  logic                   super_i,
  input  logic                   write_i,
  input  logic [1:0]             dflt_cmode_i,
  output logic                   any_hit_o,
  output logic [1:0]             cmode_o,
  output logic                   err_o
);

  always_comb begin
    any_hit_o = 1'b0;
    cmode_o   = dflt_cmode_i;
    err_o     = 1'b0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) begin
        any_hit_o = 1'b1;
        cmode_o   = cfg_i[i].cmode;
        err_o     = (cfg_i[i].sprot & ~super_i) | (cfg_i[i].wprot & write_i);
      end
    end
  end

endmodule

// File: rtl/region_attr_matcher.sv
module region_attr_matcher
  import region_attr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 4,
  parameter int unsigned WP_REGIONS  = 2,
  localparam int unsigned SEL_W      = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [WORD_W-1:0] acc_addr,
  input  logic              acc_super,
  input  logic              acc_write,
  input  logic [1:0]        dflt_cmode,
  output logic              hit,
  output logic [1:0]        cmode,
  output logic              acc_err
);

  region_cfg_t            cfg [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hit_vec;
  logic                   hit_d;
  logic [1:0]             cmode_d;
  logic                   err_d;

  region_cfg_file #(
    .NUM_REGIONS(NUM_REGIONS),
    .WP_REGIONS (WP_REGIONS)
  ) u_file (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (cfg_we),
    .sel_i  (cfg_sel),
    .wdata_i(cfg_wdata),
    .rdata_o(cfg_rdata),
    .cfg_o  (cfg)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    region_addr_cmp u_cmp (
      .cfg_i  (cfg[g]),
      .addr_i (acc_addr),
      .super_i(acc_super),
      .hit_o  (hit_vec[g])
    );
  end

  region_prio_select #(
    .NUM_REGIONS(NUM_REGIONS)
  ) u_sel (
    .hit_vec_i   (hit_vec),
    .cfg_i       (cfg),
    .super_i     (acc_super),
    .write_i     (acc_write),
    .dflt_cmode_i(dflt_cmode),
    .any_hit_o   (hit_d),
    .cmode_o     (cmode_d),
    .err_o       (err_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit     <= 1'b0;
      cmode   <= 2'b00;
      acc_err <= 1'b0;
    end else begin
      hit     <= hit_d;
      cmode   <= cmode_d;
      acc_err <= err_d;
    end
  end

endmodule

// File: rtl/region_attr_matcher_chk.sv
module region_attr_matcher_chk #(
  parameter int unsigned NUM_REGIONS = 4,
  parameter int unsigned WP_REGIONS  = 2,
  localparam int unsigned SEL_W      = $clog2(NUM_REGIONS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [SEL_W-1:0] cfg_sel,
  input logic [31:0]      cfg_rdata,
  input logic             acc_super,
  input logic             acc_write,
  input logic [1:0]       dflt_cmode,
  input logic             hit,
  input logic [1:0]       cmode,
  input logic             acc_err
);

  localparam logic [31:0] KEEP_WP   = 32'hFFFF_646C;
  localparam logic [31:0] KEEP_NOWP = 32'hFFFF_6468;

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~((32'(cfg_sel) < WP_REGIONS) ? KEEP_WP : KEEP_NOWP)) == 32'h0);

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(cfg_we) && $stable(cfg_sel) |-> $stable(cfg_rdata));

  p_miss_dflt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !hit |-> (cmode == $past(dflt_cmode)) && !acc_err);

  p_err_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> hit);

  p_super_read_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(acc_super) && !$past(acc_write) |-> !acc_err);

endmodule

bind region_attr_matcher region_attr_matcher_chk #(
  .NUM_REGIONS(NUM_REGIONS),
  .WP_REGIONS (WP_REGIONS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_rdata (cfg_rdata),
  .acc_super (acc_super),
  .acc_write (acc_write),
  .dflt_cmode(dflt_cmode),
  .hit       (hit),
  .cmode     (cmode),
  .acc_err   (acc_err)
);

// File: tb/region_attr_matcher_bench.sv
module region_attr_matcher_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [31:0] acc_addr;
  logic        acc_super;
  logic        acc_write;
  logic [1:0]  dflt_cmode;
  logic        hit;
  logic [1:0]  cmode;
  logic        acc_err;

  int checks;
  int fails;
  bit done;
  logic [31:0] m_reg [4];

  region_attr_matcher u_region_attr_matcher (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
    .acc_super(acc_super), .acc_write(acc_write), .dflt_cmode(dflt_cmode),
    .hit(hit), .cmode(cmode), .acc_err(acc_err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // R2 storable bits; bit 2 only in descriptors 0 and 1
  function automatic logic [31:0] keep_mask(int idx);
    return (idx < 2) ? 32'hFFFF_646C : 32'hFFFF_6468;
  endfunction

  function automatic logic [31:0] mk(logic [7:0] base, logic [7:0] msk, logic [1:0] pv,
                                     logic fine, logic [1:0] cm, logic sp, logic wp);
    return {base, msk, 1'b0, pv, 2'b00, fine, 3'b000, cm, 1'b0, sp, wp, 2'b00};
  endfunction

  // returns {hit, err, cmode}
  function automatic logic [3:0] model(logic [31:0] a, logic sup, logic wr, logic [1:0] dflt);
    logic h, e;
    logic [1:0] c;
    h = 1'b0; e = 1'b0; c = dflt;
    for (int k = 3; k >= 0; k--) begin
      logic [31:0] r;
      logic am, pm;
      r = m_reg[k];
      if (r[10])
        am = (a[31:24] == r[31:24]) && ((a[23:20] | r[19:16]) == (r[23:20] | r[19:16]));
      else
        am = ((a[31:24] | r[23:16]) == (r[31:24] | r[23:16]));
      pm = r[14] || (r[13] == sup);
      if (am && pm) begin
        h = 1'b1;
        c = r[6:5];
        e = (r[3] && !sup) || (k < 2 && r[2] && wr);
      end
    end
    return {h, e, c};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // one cycle: inputs driven at negedge, result compared at the next negedge
  task automatic cyc(input logic we, input logic [1:0] sel, input logic [31:0] wd,
                     input logic [31:0] a, input logic sup, input logic wr,
                     input logic [1:0] dflt, input string tag);
    logic [3:0] exp;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    acc_addr = a; acc_super = sup; acc_write = wr; dflt_cmode = dflt;
    exp = model(a, sup, wr, dflt);
    if (we) m_reg[sel] = wd & keep_mask(int'(sel));
    @(posedge clk);
    @(negedge clk);
    check(tag, {28'h0, hit, acc_err, cmode}, {28'h0, exp});
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] wd, input string tag);
    cyc(1'b1, sel, wd, 32'hFFFF_FFFF, 1'b1, 1'b0, 2'b00, tag);
  endtask

  task automatic acc(input logic [31:0] a, input logic sup, input logic wr,
                     input logic [1:0] dflt, input string tag);
    cyc(1'b0, 2'd0, 32'h0, a, sup, wr, dflt, tag);
  endtask

  task automatic rd_check(input logic [1:0] sel, input string tag);
    cfg_we = 1'b0; cfg_sel = sel;
    #1;
    check(tag, cfg_rdata, m_reg[sel]);
  endtask

  localparam logic [31:0] PARK = 32'hFF00_2000;

  initial begin
    checks = 0; fails = 0; done = 0;
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    acc_addr = 0; acc_super = 0; acc_write = 0; dflt_cmode = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outputs", {29'h0, hit, cmode}, 32'h0);
    check("R1 err", {31'h0, acc_err}, 32'h0);
    for (int i = 0; i < 4; i++) rd_check(2'(i), "R1 readback");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reserved bits and write-protect presence
    wr_reg(2'd0, 32'hFFFF_FFFF, "R2");
    wr_reg(2'd3, 32'hFFFF_FFFF, "R2");
    rd_check(2'd0, "R2 desc0");
    check("R2 desc0 value", cfg_rdata, 32'hFFFF_646C);
    rd_check(2'd3, "R2 desc3");
    check("R2 desc3 value", cfg_rdata, 32'hFFFF_6468);
    @(negedge clk);
    for (int i = 0; i < 4; i++) wr_reg(2'(i), PARK, "R2 park");

    // R3 coarse compare
    wr_reg(2'd0, mk(8'h40, 8'h00, 2'b10, 1'b0, 2'b01, 1'b0, 1'b0), "R3");
    acc(32'h4012_3456, 1'b0, 1'b0, 2'b10, "R3 hit");
    acc(32'h4100_0000, 1'b0, 1'b0, 2'b10, "R10 miss default");
    acc(32'h4100_0000, 1'b1, 1'b1, 2'b11, "R10 miss default");
    wr_reg(2'd0, mk(8'h40, 8'h03, 2'b10, 1'b0, 2'b01, 1'b0, 1'b0), "R3");
    acc(32'h43AB_CDEF, 1'b1, 1'b0, 2'b00, "R3 masked hit");
    acc(32'h4400_0000, 1'b1, 1'b0, 2'b10, "R3 unmasked miss");

    // R4 fine compare
    wr_reg(2'd1, mk(8'h80, 8'h53, 2'b10, 1'b1, 2'b11, 1'b0, 1'b0), "R4");
    acc(32'h8050_0000, 1'b0, 1'b0, 2'b00, "R4 hit");
    acc(32'h807F_FFFF, 1'b0, 1'b0, 2'b00, "R4 masked hit");
    acc(32'h80D0_0000, 1'b0, 1'b0, 2'b00, "R4 mid miss");
    acc(32'h8150_0000, 1'b0, 1'b0, 2'b00, "R4 top exact miss");

    // R5 privilege qualification
    wr_reg(2'd2, mk(8'h20, 8'h00, 2'b00, 1'b0, 2'b10, 1'b0, 1'b0), "R5");
    acc(32'h2000_0000, 1'b0, 1'b0, 2'b01, "R5 user only hit");
    acc(32'h2000_0000, 1'b1, 1'b0, 2'b01, "R5 user only miss");
    wr_reg(2'd2, mk(8'h20, 8'h00, 2'b01, 1'b0, 2'b10, 1'b0, 1'b0), "R5");
    acc(32'h2000_0000, 1'b1, 1'b0, 2'b01, "R5 super only hit");
    acc(32'h2000_0000, 1'b0, 1'b0, 2'b01, "R5 super only miss");

    // R6 / R7 supervisor-only region
    wr_reg(2'd3, mk(8'h30, 8'h00, 2'b11, 1'b0, 2'b00, 1'b1, 1'b0), "R7");
    acc(32'h3000_0010, 1'b0, 1'b0, 2'b11, "R7 user error");
    acc(32'h3000_0010, 1'b1, 1'b1, 2'b11, "R7 super ok");
    acc(32'h3000_0010, 1'b1, 1'b0, 2'b11, "R6 cmode 00");

    // R8 write protect
    wr_reg(2'd0, mk(8'h40, 8'h00, 2'b10, 1'b0, 2'b01, 1'b0, 1'b1), "R8");
    acc(32'h4000_0000, 1'b1, 1'b1, 2'b00, "R8 write error");
    acc(32'h4000_0000, 1'b1, 1'b0, 2'b00, "R8 read ok");
    wr_reg(2'd2, mk(8'h20, 8'h00, 2'b10, 1'b0, 2'b10, 1'b0, 1'b1), "R8");
    rd_check(2'd2, "R8 desc2 bit2 zero");
    check("R8 desc2 bit2", {31'h0, cfg_rdata[2]}, 32'h0);
    @(negedge clk);
    acc(32'h2000_0000, 1'b0, 1'b1, 2'b00, "R8 desc2 no write error");

    // R9 priority
    wr_reg(2'd0, mk(8'h60, 8'h00, 2'b10, 1'b0, 2'b01, 1'b0, 1'b0), "R9");
    wr_reg(2'd1, mk(8'h60, 8'h00, 2'b10, 1'b0, 2'b10, 1'b1, 1'b0), "R9");
    acc(32'h6000_0000, 1'b0, 1'b0, 2'b11, "R9 lowest wins");
    wr_reg(2'd0, PARK, "R9");
    acc(32'h6000_0000, 1'b0, 1'b0, 2'b11, "R9 next wins");

    // R11 same-cycle write uses old contents
    cyc(1'b1, 2'd1, PARK, 32'h6000_0000, 1'b0, 1'b0, 2'b00, "R11 old contents");
    acc(32'h6000_0000, 1'b0, 1'b0, 2'b00, "R11 new contents");

    // R6 random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      logic [1:0]  s;
      s = 2'($urandom_range(0, 3));
      a = $urandom;
      if ($urandom_range(0, 3) != 0) a[31:20] = {m_reg[s][31:24], m_reg[s][23:20] ^ 4'($urandom_range(0, 3))};
      cyc(($urandom_range(0, 5) == 0), 2'($urandom_range(0, 3)),
          ($urandom & 32'hFFFF_FFFF), a, 1'($urandom), 1'($urandom),
          2'($urandom), "R6 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule